// File: doc/BRIEF.md
# Load/Store and Register-Block Transfer Stage

This is the memory access stage of a 32-bit load/store core. The stage takes one operation per issue: a byte, halfword or word load or store at the address formed by base plus offset, or a block transfer. A block transfer copies a run of registers, from a chosen first register up to the highest register, into consecutive memory words, or fills that run from them. Block transfers give a short path for saving and restoring context. The stage drives a request/ready data-memory port with per-byte lane enables. It reads store data through a register-file read port and writes load results through a register-file write port.

A single access takes two clocks: the issue clock, then one memory clock. A block transfer of N registers takes N+1 clocks: the issue clock, then one memory word per clock. While the stage is working, `busy` tells the issue logic to hold the next operation. A sub-word load always fills the upper bits with zeros. An access that is not naturally aligned is refused: the stage raises a one-clock `misalign` pulse and touches neither memory nor the register file.

The controller is a three-state machine:
- S_IDLE waits for issue.
- S_SINGLE performs one access.
- S_MULTI steps through the register run.

Its transitions are:
- T_ISSUE_ONE goes from S_IDLE to S_SINGLE on an aligned single access.
- T_ISSUE_RUN goes from S_IDLE to S_MULTI on an aligned block transfer.
- T_REJECT stays in S_IDLE on a misaligned issue and raises the flag.
- T_WAIT holds S_SINGLE or S_MULTI while `mem_ready` is low.
- T_DONE_ONE goes from S_SINGLE to S_IDLE once the access is accepted.
- T_STEP stays in S_MULTI and advances register and address after each accepted word below the last register.
- T_DONE_RUN goes from S_MULTI to S_IDLE after the last register.

Top module: `lsm_unit`

## Requirements
- R1: After reset, `busy`, `mem_req`, `rf_we` and `misalign` are all 0.
- R2: The effective address is `op_base + op_offset`, and it appears on `mem_addr` for a single access. Lane enables are little-endian:
  - byte (size 00): `mem_be = 1 << addr[1:0]`;
  - halfword (size 01): `4'b0011` when `addr[1]` is 0, else `4'b1100`;
  - word (size 10 or 11) and every block transfer: `4'b1111`.
- R3: For a store (kind 01), `mem_wdata` replicates the source register's low byte into all four lanes for a byte store. It replicates the low halfword into both halves for a halfword store, and carries the full register for a word store. The source register is `op_reg`, read on `rf_rd_addr`.
- R4: For a load (kind 00), register `op_reg` is written through the write port with zero-extended data. A byte load writes bits `8*addr[1:0]+7 : 8*addr[1:0]` of `mem_rdata`. A halfword load writes `mem_rdata[31:16]` when `addr[1]` is 1, else `mem_rdata[15:0]`. A word load writes all of `mem_rdata`.
- R5: An accepted single access raises `mem_req` in the clock after issue. With `mem_ready` high, `busy` stays high for exactly that one clock, so the operation takes two clocks.
- R6: A block load (kind 10) with first register F moves registers F..15, one per clock, in ascending order, to addresses EA, EA+4, and so on. Each word read is written to its register. With `mem_ready` high, `busy` stays high for N = 16-F clocks, so the transfer takes N+1 clocks.
- R7: A block store (kind 11) drives register F+i, read on `rf_rd_addr`, as the full word at EA+4i, with `mem_we` high.
- R8: `busy` is high whenever an access or transfer is in progress. An `op_valid` presented while `busy` is high is ignored and causes no memory access.
- R9: A halfword at an odd address, or a word or block transfer whose address has `addr[1:0]` different from 0, is refused. `misalign` is high for exactly the clock after issue, with no memory request, no register write and `busy` low.
- R10: While `mem_req` is high and `mem_ready` is low, the step in progress is held with the same address and register. It completes on the first clock with `mem_ready` high, and each stalled clock adds one clock to the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue request |
| op_kind | input | 2 | 00 load, 01 store, 10 block load, 11 block store |
| op_size | input | 2 | 00 byte, 01 halfword, 10/11 word (single accesses only) |
| op_base | input | 32 | Base address |
| op_offset | input | 32 | Address offset |
| op_reg | input | 4 | Data register (single) or first register (block) |
| busy | output | 1 | Operation in progress, hold issue |
| misalign | output | 1 | One-clock pulse for a refused unaligned access |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts or completes the request this clock |
| rf_rd_addr | output | 4 | Register-file read address for store data |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |

## Verification
The hardest case to reach is a memory stall that lands in the middle of a block transfer, after some words have completed and before the last. The bench reaches it by running a block store alongside a process that counts clocks from issue and pulls `mem_ready` low for two clocks on the second word. The scoreboard then expects every word exactly once, and the cycle count expects N+3 clocks. A second concurrent process offers a new operation while a block load is busy, to show that the operation never reaches the memory port.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_MULTI  = 2'd2
    } lsm_state_t;

    // Natural alignment rule; block transfers always move whole words.
    function automatic logic misaligned(input logic [1:0] size,
                                        input logic [1:0] lo,
                                        input logic       multi);
        if (multi || size[1])
            return lo != 2'b00;
        else if (size == SZ_HALF)
            return lo[0];
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/lsm_lane.sv
module lsm_lane
    import lsm_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        lo,
    input  logic              wide,
    input  logic [DATA_W-1:0] st_src,
    input  logic [DATA_W-1:0] ld_raw,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] ld_data
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = ld_raw >> {lo, 3'b000};
        if (wide || size[1]) begin
            be      = '1;
            st_data = st_src;
            ld_data = ld_raw;
        end else if (size == SZ_HALF) begin
            be      = lo[1] ? 4'b1100 : 4'b0011;
            st_data = {2{st_src[15:0]}};
            ld_data = {16'b0, shifted[15:0]};
        end else begin
            be      = 4'b0001 << lo;
            st_data = {4{st_src[7:0]}};
            ld_data = {24'b0, shifted[7:0]};
        end
    end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_size,
    input  logic [ADDR_W-1:0] ea,
    input  logic [REG_W-1:0]  op_reg,
    input  logic              mem_ready,
    output logic              busy,
    output logic              act,
    output logic              misal_q,
    output logic [1:0]        kind_q,
    output logic [1:0]        size_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [REG_W-1:0]  reg_q
);

    localparam logic [REG_W-1:0]  LAST = REG_W'(NREG - 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BE_W);

    lsm_state_t state, nstate;
    logic       accept, bad, last;

    assign accept = op_valid && (state == S_IDLE);
    assign bad    = accept && misaligned(op_size, ea[1:0], op_kind[1]);
    assign last   = (reg_q == LAST);

    // Next-state selection
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (accept && !bad)
                    nstate = op_kind[1] ? S_MULTI : S_SINGLE;  // T_ISSUE_RUN / T_ISSUE_ONE
            end
            S_SINGLE: begin
                if (mem_ready) nstate = S_IDLE;                // T_DONE_ONE
            end
            S_MULTI: begin
                if (mem_ready && last) nstate = S_IDLE;        // T_DONE_RUN
            end
            default: nstate = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= '0;
            size_q  <= '0;
            addr_q  <= '0;
            reg_q   <= '0;
            misal_q <= 1'b0;
        end else begin
            misal_q <= bad;
            if (accept && !bad) begin
                kind_q <= op_kind;
                size_q <= op_size;
                addr_q <= ea;
                reg_q  <= op_reg;
            end else if (state == S_MULTI && mem_ready && !last) begin  // T_STEP
                addr_q <= addr_q + STEP;
                reg_q  <= reg_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state != S_IDLE);
        act  = (state == S_SINGLE) || (state == S_MULTI);
    end

    p_single_two_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bad && !op_kind[1]) |=> (act && busy));

    p_single_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SINGLE && mem_ready) |=> !busy);

    p_misalign_noacc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (misal_q && !act && !busy));

    p_multi_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MULTI && mem_ready && !last) |=>
            (act && addr_q == $past(addr_q) + STEP && reg_q == $past(reg_q) + 1'b1));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !mem_ready) |=> (act && $stable(addr_q) && $stable(reg_q)));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && !(act && mem_ready)) |=> ($stable(kind_q) && !misal_q));

endmodule

// File: rtl/lsm_unit.sv
module lsm_unit
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_size,
    input  logic [ADDR_W-1:0] op_base,
    input  logic [ADDR_W-1:0] op_offset,
    input  logic [REG_W-1:0]  op_reg,
    output logic              busy,
    output logic              misalign,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [REG_W-1:0]  rf_rd_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    logic [ADDR_W-1:0] ea;
    logic              act;
    logic              misal_q;
    logic [1:0]        kind_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  reg_q;
    logic [BE_W-1:0]   be_w;
    logic [DATA_W-1:0] st_w;
    logic [DATA_W-1:0] ld_w;

    assign ea = op_base + op_offset;

    lsm_seq #(.ADDR_W(ADDR_W), .NREG(NREG)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_size   (op_size),
        .ea        (ea),
        .op_reg    (op_reg),
        .mem_ready (mem_ready),
        .busy      (busy),
        .act       (act),
        .misal_q   (misal_q),
        .kind_q    (kind_q),
        .size_q    (size_q),
        .addr_q    (addr_q),
        .reg_q     (reg_q)
    );

    lsm_lane u_lane (
        .size    (size_q),
        .lo      (addr_q[1:0]),
        .wide    (kind_q[1]),
        .st_src  (rf_rd_data),
        .ld_raw  (mem_rdata),
        .be      (be_w),
        .st_data (st_w),
        .ld_data (ld_w)
    );

    always_comb begin
        misalign   = misal_q;
        mem_req    = act;
        mem_we     = act && kind_q[0];
        mem_addr   = addr_q;
        mem_be     = be_w;
        mem_wdata  = st_w;
        rf_rd_addr = reg_q;
        rf_we      = act && !kind_q[0] && mem_ready;
        rf_waddr   = reg_q;
        rf_wdata   = ld_w;
    end

    p_rfwe_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ready && !mem_we));

    p_be_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !kind_q[1] && size_q == SZ_BYTE) |-> ($countones(mem_be) == 1));

    p_be_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && kind_q[1]) |-> (mem_be == '1 && mem_addr[1:0] == 2'b00));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we));

endmodule

// File: tb/lsm_unit_test.sv
module lsm_unit_test;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [3:0]  waddr;
        logic [31:0] rdata;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] op_base = '0;
    logic [31:0] op_offset = '0;
    logic [3:0]  op_reg = '0;
    logic        busy, misalign, mem_req, mem_we, rf_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wdata;
    logic [3:0]  mem_be, rf_rd_addr, rf_waddr;
    logic        mem_ready = 1'b1;

    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] regval(input logic [3:0] i);
        return 32'h9E3779B1 ^ {4{4'h0, i}};
    endfunction

    function automatic logic [31:0] memval(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return {w[15:8] ^ 8'hC0, w[7:0] ^ 8'hDE, ~w[15:8], ~w[7:0]};
    endfunction

    assign rf_rd_data = regval(rf_rd_addr);
    assign mem_rdata  = memval(mem_addr);

    lsm_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_size(op_size), .op_base(op_base), .op_offset(op_offset), .op_reg(op_reg),
        .busy(busy), .misalign(misalign), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each accepted memory step with the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && mem_req && mem_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected access at", mem_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(mem_addr == e.addr, e.req, "mem_addr", mem_addr, e.addr);
                    chk(mem_be == e.be, e.req, "mem_be", {28'h0, mem_be}, {28'h0, e.be});
                    chk(mem_we == e.we, e.req, "mem_we", {31'h0, mem_we}, {31'h0, e.we});
                    if (e.we) begin
                        chk(mem_wdata == e.wdata, e.req, "mem_wdata", mem_wdata, e.wdata);
                        chk(!rf_we, e.req, "rf_we on store", {31'h0, rf_we}, 32'h0);
                    end else begin
                        chk(rf_we && rf_waddr == e.waddr, e.req, "rf_waddr",
                            {27'h0, rf_we, rf_waddr}, {27'h0, 1'b1, e.waddr});
                        chk(rf_wdata == e.rdata, e.req, "rf_wdata", rf_wdata, e.rdata);
                    end
                end
            end
        end
    end

    // Driver: push expected items, issue, and count busy clocks
    task automatic do_op(input logic [1:0] k, input logic [1:0] sz,
                         input logic [31:0] b, input logic [31:0] o,
                         input logic [3:0] r, input int exp_busy, input string req);
        logic [31:0] ea;
        int cnt;
        ea = b + o;
        if (!k[1]) begin
            exp_t e;
            logic [31:0] raw, sh;
            raw = memval(ea);
            sh  = raw >> (8 * ea[1:0]);
            e.we = k[0]; e.addr = ea; e.waddr = r; e.req = req;
            if (sz[1]) begin
                e.be = 4'hF; e.wdata = regval(r); e.rdata = raw;
            end else if (sz == 2'b01) begin
                e.be = ea[1] ? 4'hC : 4'h3;
                e.wdata = {2{regval(r)[15:0]}};
                e.rdata = {16'h0, sh[15:0]};
            end else begin
                e.be = 4'h1 << ea[1:0];
                e.wdata = {4{regval(r)[7:0]}};
                e.rdata = {24'h0, sh[7:0]};
            end
            sb.push_back(e);
        end else begin
            for (int i = int'(r); i < 16; i++) begin
                exp_t e;
                e.we = k[0]; e.addr = ea + 32'(4 * (i - int'(r))); e.be = 4'hF;
                e.waddr = 4'(i); e.wdata = regval(4'(i)); e.rdata = memval(e.addr);
                e.req = req;
                sb.push_back(e);
            end
        end
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_size = sz; op_base = b; op_offset = o; op_reg = r;
        @(negedge clk);
        op_valid = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp_busy, req, "busy clocks", 32'(cnt), 32'(exp_busy));
    endtask

    task automatic bad_op(input logic [1:0] k, input logic [1:0] sz,
                          input logic [31:0] b, input string what);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_size = sz; op_base = b; op_offset = 32'h0; op_reg = 4'd3;
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk(misalign && !mem_req && !busy && !rf_we, "R9", what,
            {28'h0, misalign, mem_req, busy, rf_we}, 32'h8);
        @(negedge clk);
        #1;
        chk(!misalign, "R9", "flag lasts one clock", {31'h0, misalign}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_req && !rf_we && !misalign, "R1", "reset outputs",
            {28'h0, busy, mem_req, rf_we, misalign}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !mem_req && !misalign, "R1", "after reset release",
            {29'h0, busy, mem_req, misalign}, 32'h0);

        // R2/R4/R5: byte loads in every lane, base plus offset
        for (int l = 0; l < 4; l++)
            do_op(2'b00, 2'b00, 32'h0000_1200, 32'(16 + l), 4'(l + 1), 1, "R4");
        do_op(2'b00, 2'b01, 32'h0000_3400, 32'h0000_0000, 4'd5, 1, "R4");
        do_op(2'b00, 2'b01, 32'h0000_3400, 32'h0000_0002, 4'd6, 1, "R2");
        do_op(2'b00, 2'b10, 32'h0000_5600, 32'h0000_0008, 4'd7, 1, "R5");
        // R3: stores of each size
        do_op(2'b01, 2'b00, 32'h0000_7000, 32'h0000_0003, 4'd8, 1, "R3");
        do_op(2'b01, 2'b01, 32'h0000_7000, 32'h0000_0006, 4'd9, 1, "R3");
        do_op(2'b01, 2'b11, 32'h0000_7000, 32'h0000_000C, 4'd10, 1, "R3");
        // R6/R7: block transfers
        do_op(2'b10, 2'b00, 32'h0000_8000, 32'h0000_0010, 4'd12, 4, "R6");
        do_op(2'b10, 2'b00, 32'h0000_8100, 32'h0000_0000, 4'd15, 1, "R6");
        do_op(2'b11, 2'b00, 32'h0000_9000, 32'h0000_0020, 4'd13, 3, "R7");
        // R9: refused accesses
        bad_op(2'b00, 2'b01, 32'h0000_A001, "odd halfword refused");
        bad_op(2'b01, 2'b10, 32'h0000_A002, "unaligned word refused");
        bad_op(2'b10, 2'b00, 32'h0000_A004 + 32'h1, "unaligned block refused");
        // R8: issue attempt while busy is ignored
        fork
            do_op(2'b10, 2'b00, 32'h0000_B000, 32'h0, 4'd10, 6, "R8");
            begin
                repeat (3) @(negedge clk);
                op_valid = 1'b1; op_kind = 2'b01; op_size = 2'b10;
                op_base = 32'h0000_C000; op_offset = 32'h0; op_reg = 4'd2;
                @(negedge clk);
                op_valid = 1'b0;
            end
        join
        // R10: two stalled clocks in the middle of a block store
        fork
            do_op(2'b11, 2'b00, 32'h0000_D000, 32'h0, 4'd12, 6, "R10");
            begin
                repeat (3) @(negedge clk);
                mem_ready = 1'b0;
                repeat (2) @(negedge clk);
                mem_ready = 1'b1;
            end
        join
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R6", "all expected steps seen", 32'(sb.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule